// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the array address for a synchronous burst memory. A start address is captured from the address bus when either of two start strobes is seen on a rising clock edge. The processor-side strobe is honoured only while the chip enable is high. The controller-side strobe loads whatever the state of the enable or of the other strobe.

After a load, the two low address bits walk through a four-beat burst. They move by one beat on each edge where the advance input is high and no strobe loads. The upper bits keep the captured value. A burst order input, captured together with the address, picks either a linear count (add modulo 4) or an interleaved count (start XOR beat). With neither a strobe nor advance present, the address is held, which suspends the burst.

A fresh address may be loaded on every cycle with no idle cycles between loads, so the block also serves plain single-beat accesses. The output address and a burst-active flag come from registers and change only after a rising edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and until the first load, `addr_out` is all zeros and `burst_active` is 0.
- R2: On an edge where `proc_strobe` and `chip_en` are both 1, `addr_in` is captured. From the next cycle `addr_out` equals it and `burst_active` is 1.
- R3: When `chip_en` is 0, `proc_strobe` has no effect. With `ctrl_strobe` and `advance` also 0, `addr_out` and `burst_active` keep their values.
- R4: On an edge where `ctrl_strobe` is 1, `addr_in` is captured whatever the values of `chip_en` and `proc_strobe`. When both strobes are valid, the processor strobe has priority; the captured value is the same either way.
- R5: With `order_linear` = 1 captured at load, beat k (k = 0..3) shows low bits equal to (start low bits + k) mod 4.
- R6: With `order_linear` = 0 captured at load, beat k shows low bits equal to start low bits XOR k. The order input has no effect except at a load.
- R7: On an edge with `advance` = 1 and no valid strobe, the beat counter steps once. On an edge with no valid strobe and `advance` = 0, `addr_out` and `burst_active` keep their values.
- R8: The fourth advance after a load wraps the low bits back to their start value and clears `burst_active`. Bits above bit 1 of `addr_out` never change except through a load.
- R9: A valid strobe overrides `advance` on the same edge. Loads on consecutive edges each show their own address one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Qualifies the processor strobe |
| proc_strobe | input | 1 | Processor-side burst start |
| ctrl_strobe | input | 1 | Controller-side burst start, ungated |
| advance | input | 1 | Steps the burst one beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order; captured at load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array address |
| burst_active | output | 1 | High from a load until the wrapping advance |

## Verification
The bench sweeps every start value of the low bits in both orders and through both strobes. It checks each of the four beats and the wrap. A swapped order would give a pattern such as 1,2,3,0 where 1,0,3,2 is expected, and a carry leaking out of the low bits would change the upper address on a wrap. It also sends the processor strobe with the enable low, strobes together with advance, long suspends and loads on every cycle. A design that ungated the strobe, let advance win over a load, or drifted during a suspend would show the wrong address on the next cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_STEP = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_act_e;
endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb
  import burst_seq_pkg::*;
(
  input  logic     chip_en,
  input  logic     proc_strobe,
  input  logic     ctrl_strobe,
  input  logic     advance,
  output seq_act_e act
);
  always_comb begin
    if (proc_strobe && chip_en) act = SEQ_LOAD;   // processor strobe first
    else if (ctrl_strobe)       act = SEQ_LOAD;   // controller strobe, ungated
    else if (advance)           act = SEQ_STEP;
    else                        act = SEQ_HOLD;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_act_e          act,
  output logic [BEAT_W-1:0] beat,
  output logic              active
);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  logic [BEAT_W-1:0] beat_d;
  logic              active_d;
  logic              en;

  always_comb begin
    beat_d   = beat;
    active_d = active;
    en       = 1'b0;
    case (act)
      SEQ_LOAD: begin
        beat_d   = '0;
        active_d = 1'b1;
        en       = 1'b1;
      end
      SEQ_STEP: begin
        beat_d = beat + 1'b1;
        if (beat == LAST) active_d = 1'b0;
        en = 1'b1;
      end
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat   <= '0;
      active <= 1'b0;
    end else if (en) begin
      beat   <= beat_d;
      active <= active_d;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  logic              linear,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] sum;
  logic [BEAT_W-1:0] mix;

  assign sum = start + beat;
  assign mix = start ^ beat;
  assign low = linear ? sum : mix;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  seq_act_e          act;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              lin_q, lin_d;
  logic              load_en;

  burst_start_arb u_arb (
    .chip_en     (chip_en),
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .advance     (advance),
    .act         (act)
  );

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act    (act),
    .beat   (beat),
    .active (burst_active)
  );

  always_comb begin
    load_en = (act == SEQ_LOAD);
    base_d  = addr_in;
    lin_d   = order_linear;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
      lin_q  <= 1'b1;
    end else if (load_en) begin
      base_q <= base_d;
      lin_q  <= lin_d;
    end
  end

  burst_order_map u_map (
    .linear (lin_q),
    .start  (base_q[BEAT_W-1:0]),
    .beat   (beat),
    .low    (low)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};
    end else begin : g_lo
      assign addr_out = low;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              proc_strobe,
  input logic              ctrl_strobe,
  input logic              advance,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active
);
  logic valid_ld;
  assign valid_ld = (proc_strobe && chip_en) || ctrl_strobe;

  a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && chip_en) |=> (addr_out == $past(addr_in)) && burst_active);

  a_r4_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_strobe |=> (addr_out == $past(addr_in)) && burst_active);

  a_r3_gated_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && !chip_en && !ctrl_strobe && !advance) |=>
      $stable(addr_out) && $stable(burst_active));

  a_r7_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_ld && !advance) |=> $stable(addr_out) && $stable(burst_active));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_ld |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  a_r8_no_reactivate: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_ld && !burst_active) |=> !burst_active);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .chip_en      (chip_en),
  .proc_strobe  (proc_strobe),
  .ctrl_strobe  (ctrl_strobe),
  .advance      (advance),
  .addr_in      (addr_in),
  .addr_out     (addr_out),
  .burst_active (burst_active)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0, proc_strobe = 1'b0, ctrl_strobe = 1'b0;
  logic          advance = 1'b0, order_linear = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0, failures = 0;

  // model state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic          m_lin = 1'b1;
  logic          m_act = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .proc_strobe(proc_strobe),
    .ctrl_strobe(ctrl_strobe), .advance(advance), .order_linear(order_linear),
    .addr_in(addr_in), .addr_out(addr_out), .burst_active(burst_active)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_lin ? 2'((int'(m_base[1:0]) + m_beat) % 4) : (m_base[1:0] ^ 2'(m_beat));
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = exp_addr();
    checks++;
    if (addr_out !== ea || burst_active !== m_act) begin
      failures++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
               tag, addr_out, burst_active, ea, m_act);
    end
  endtask

  task automatic cyc(input logic ce, input logic ps, input logic cs, input logic adv,
                     input logic ord, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    chip_en = ce; proc_strobe = ps; ctrl_strobe = cs; advance = adv;
    order_linear = ord; addr_in = a;
    if ((ps && ce) || cs) begin
      m_base = a; m_beat = 0; m_lin = ord; m_act = 1'b1;
    end else if (adv) begin
      if (m_beat == 3) m_act = 1'b0;
      m_beat = (m_beat + 1) % 4;
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after release");

    // R5/R6/R8: every low start, both orders, both strobes, 4 beats and wrap
    for (int ord = 0; ord < 2; ord++)
      for (int st = 0; st < 4; st++)
        for (int which = 0; which < 2; which++) begin
          logic [AW-1:0] a;
          a = AW'(8'hA4 + st + 16 * which + 64 * ord);
          if (which == 0) cyc(1, 1, 0, 0, ord[0], a, "R2 proc load");
          else            cyc(0, 0, 1, 0, ord[0], a, "R4 ctrl load");
          for (int k = 1; k <= 4; k++) begin
            cyc(0, 0, 0, 1, ~ord[0], 8'h00, ord ? "R5 linear beat" : "R6 interleave beat");
            if (k == 4) begin
              checks++;
              if (addr_out !== a || burst_active !== 1'b0) begin
                failures++;
                $display("FAIL R8 wrap: addr=%h act=%b expected addr=%h act=0",
                         addr_out, burst_active, a);
              end
            end
          end
          cyc(0, 0, 0, 1, 1'b0, 8'h00, "R8 advance after wrap");
        end

    // R3: gated processor strobe ignored
    cyc(1, 1, 0, 0, 1, 8'h31, "R2 load");
    cyc(0, 1, 0, 0, 0, 8'hEE, "R3 gated ignore");
    cyc(0, 1, 0, 1, 0, 8'hEE, "R3 gated, advance steps");
    // R4: ctrl with proc+enable, and ctrl with enable low
    cyc(1, 1, 1, 0, 0, 8'h5B, "R4 both strobes");
    cyc(0, 1, 1, 1, 1, 8'h6E, "R4 ctrl ungated");
    // R7: suspend
    cyc(0, 0, 0, 1, 0, 8'hFF, "R7 step");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 8'hFF, "R7 suspend hold");
    cyc(0, 0, 0, 1, 0, 8'hFF, "R7 resume");
    // R9: strobe overrides advance; load every cycle
    cyc(1, 1, 0, 1, 0, 8'h93, "R9 strobe over advance");
    for (int i = 0; i < 16; i++)
      cyc(i[0], 1, ~i[0], i[1], i[2], AW'(i * 37 + 5), "R9 back-to-back load");
    // R8: upper bits untouched across many wraps
    cyc(0, 0, 1, 0, 1, 8'hFF, "R8 load top");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 1, 8'h00, "R8 upper fixed");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule